// File: doc/BRIEF.md
# One-Bit Ladder Logic Controller

This block is the execution core of a bit-serial controller for relay-ladder-style programs. In every clock cycle it takes a 4-bit opcode and one data bit from outside, works on three one-bit state registers, and answers through a store strobe, a driven data bit and single-cycle flag pulses. The state registers are an accumulating result bit, an input gate and an output gate. Program memory, the program counter and the I/O latches are outside the block. The jump and return flags go to that external sequencer, and the core does no address handling of its own.

The result bit is combined with the incoming data bit by logical operations, or stored out. Two software-loaded enable bits qualify data in and data out. Conditional execution works by suppressing the next instruction, not by branching. Every output is registered: an opcode sampled at rising edge N shows its effect on the outputs and on `rr_o` after that edge, and the effect lasts until edge N+1. The opcode stream has no handshake. The core accepts one instruction every cycle and never applies back-pressure, so the sequencer must present a valid opcode on every cycle.

Top module: `icu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the result bit, both enable bits and any pending skip. While `rst` is high, every output reads 0.
- R2: With the input gate set, opcodes 1 to 7 write the result bit from the data bit d and the old result r. The codes are 1: d, 2: not d, 3: r and d, 4: r and not d, 5: r or d, 6: r or not d, 7: 1 when r equals d and 0 otherwise.
- R3: With the input gate clear, opcodes 1 to 7 see the data bit as 0, whatever `data_i` carries.
- R4: With the output gate set, opcode 8 stores the result bit and opcode 9 stores its complement. For exactly one cycle after the opcode is sampled, `wr_o` and `data_oe_o` are 1 and `data_o` carries the stored value. `data_o` reads 0 whenever `data_oe_o` is 0.
- R5: With the output gate clear, opcodes 8 and 9 produce no write pulse and no bus drive.
- R6: Opcode A loads the raw `data_i` bit into the input gate, and opcode B loads it into the output gate. The input gate itself does not affect these loads.
- R7: Opcodes C, 0 and F pulse `jmp_o`, `flg0_o` and `flgf_o` respectively for one cycle, and leave all state unchanged.
- R8: Opcode D pulses `rtn_o` for one cycle and suppresses the next instruction.
- R9: Opcode E suppresses the next instruction when the result bit is 0, and has no effect when it is 1.
- R10: A suppressed instruction changes no state and gives no write or flag pulse. The suppression covers exactly one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Opcode for this cycle |
| data_i | input | 1 | Data bit read from the external bus |
| data_o | output | 1 | Data bit driven during an enabled store |
| data_oe_o | output | 1 | Bus driver enable |
| wr_o | output | 1 | Write strobe to the external latches |
| jmp_o | output | 1 | Jump flag pulse |
| rtn_o | output | 1 | Return flag pulse |
| flg0_o | output | 1 | Flag pulse for opcode 0 |
| flgf_o | output | 1 | Flag pulse for opcode F |
| rr_o | output | 1 | Current result bit |

## Verification
The core has no size parameters, so the bench builds it in its only configuration. Because the whole state is four bits, a full sweep is possible. The bench covers every pair of consecutive opcodes, under every combination of result bit, input gate, output gate and data bit. This exercises the gating cases, both suppressing opcodes followed by each of the 16 opcodes, and the instruction that follows a suppressed one.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int OP_W = 4;
  localparam int FN_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP0 = 4'h0, OP_LD   = 4'h1, OP_LDC  = 4'h2, OP_AND  = 4'h3,
    OP_ANDC = 4'h4, OP_OR   = 4'h5, OP_ORC  = 4'h6, OP_XNOR = 4'h7,
    OP_STO  = 4'h8, OP_STOC = 4'h9, OP_IEN  = 4'hA, OP_OEN  = 4'hB,
    OP_JMP  = 4'hC, OP_RTN  = 4'hD, OP_SKZ  = 4'hE, OP_NOPF = 4'hF
  } icu_op_e;

  typedef struct packed {
    logic rr_we;
    logic store;
    logic store_inv;
    logic ien_we;
    logic oen_we;
    logic jmp;
    logic rtn;
    logic skz;
    logic flg0;
    logic flgf;
  } icu_ctl_t;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            kill,
  output icu_ctl_t        ctl
);
  always_comb begin
    ctl = '0;
    if (!kill) begin
      case (icu_op_e'(op))
        OP_LD, OP_LDC, OP_AND, OP_ANDC,
        OP_OR, OP_ORC, OP_XNOR: ctl.rr_we = 1'b1;
        OP_STO:  ctl.store = 1'b1;
        OP_STOC: begin ctl.store = 1'b1; ctl.store_inv = 1'b1; end
        OP_IEN:  ctl.ien_we = 1'b1;
        OP_OEN:  ctl.oen_we = 1'b1;
        OP_JMP:  ctl.jmp = 1'b1;
        OP_RTN:  ctl.rtn = 1'b1;
        OP_SKZ:  ctl.skz = 1'b1;
        OP_NOP0: ctl.flg0 = 1'b1;
        OP_NOPF: ctl.flgf = 1'b1;
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/icu_logic.sv
module icu_logic
  import icu_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  logic            rr,
  input  logic            din,
  output logic            res
);
  always_comb begin
    case (fn)
      3'd1:    res = din;
      3'd2:    res = ~din;
      3'd3:    res = rr & din;
      3'd4:    res = rr & ~din;
      3'd5:    res = rr | din;
      3'd6:    res = rr | ~din;
      3'd7:    res = ~(rr ^ din);
      default: res = rr;
    endcase
  end
endmodule

// File: rtl/icu_core.sv
module icu_core
  import icu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic            data_i,
  output logic            data_o,
  output logic            data_oe_o,
  output logic            wr_o,
  output logic            jmp_o,
  output logic            rtn_o,
  output logic            flg0_o,
  output logic            flgf_o,
  output logic            rr_o
);
  logic rr_q, ien_q, oen_q, skip_q;
  logic wr_q, bus_q, jmp_q, rtn_q, flg0_q, flgf_q;
  logic din_gated, lu_res, store_en;
  icu_ctl_t ctl;

  icu_decode u_dec (
    .op   (op_i),
    .kill (skip_q),
    .ctl  (ctl)
  );

  assign din_gated = data_i & ien_q;

  icu_logic u_lu (
    .fn  (op_i[FN_W-1:0]),
    .rr  (rr_q),
    .din (din_gated),
    .res (lu_res)
  );

  assign store_en = ctl.store & oen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q   <= 1'b0;
      ien_q  <= 1'b0;
      oen_q  <= 1'b0;
      skip_q <= 1'b0;
      wr_q   <= 1'b0;
      bus_q  <= 1'b0;
      jmp_q  <= 1'b0;
      rtn_q  <= 1'b0;
      flg0_q <= 1'b0;
      flgf_q <= 1'b0;
    end else begin
      if (ctl.rr_we)  rr_q  <= lu_res;
      if (ctl.ien_we) ien_q <= data_i;
      if (ctl.oen_we) oen_q <= data_i;
      skip_q <= ctl.rtn | (ctl.skz & ~rr_q);
      wr_q   <= store_en;
      bus_q  <= store_en & (rr_q ^ ctl.store_inv);
      jmp_q  <= ctl.jmp;
      rtn_q  <= ctl.rtn;
      flg0_q <= ctl.flg0;
      flgf_q <= ctl.flgf;
    end
  end

  assign data_o    = bus_q;
  assign data_oe_o = wr_q;
  assign wr_o      = wr_q;
  assign jmp_o     = jmp_q;
  assign rtn_o     = rtn_q;
  assign flg0_o    = flg0_q;
  assign flgf_o    = flgf_q;
  assign rr_o      = rr_q;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_q, jmp_q, rtn_q, flg0_q, flgf_q})); // R7
  AST_SKIP_KEEPS_RR: assert property (@(posedge clk) disable iff (rst)
    skip_q |=> $stable(rr_q)); // R10
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    skip_q |=> !(wr_q || jmp_q || rtn_q || flg0_q || flgf_q)); // R10
  AST_SKIP_ONCE: assert property (@(posedge clk) disable iff (rst)
    skip_q |=> !skip_q); // R10
  AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> oen_q); // R5
  AST_RTN_SKIPS: assert property (@(posedge clk) disable iff (rst)
    rtn_q |-> skip_q); // R8
  AST_IEN_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!ien_q && !skip_q && op_i == OP_LD) |=> !rr_q); // R3
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> !data_o); // R4
endmodule

// File: tb/tb_icu_core.sv
`timescale 1ns/100ps
module tb_icu_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_i = 4'h0;
  logic data_i = 1'b0;
  logic data_o, data_oe_o, wr_o, jmp_o, rtn_o, flg0_o, flgf_o, rr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit m_rr, m_ien, m_oen, m_skip;

  always #2.5 clk = ~clk;

  icu_core dut (
    .clk(clk), .rst(rst), .op_i(op_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .wr_o(wr_o),
    .jmp_o(jmp_o), .rtn_o(rtn_o), .flg0_o(flg0_o), .flgf_o(flgf_o),
    .rr_o(rr_o)
  );

  function automatic logic [7:0] outs();
    return {rr_o, wr_o, data_oe_o, data_o, jmp_o, rtn_o, flg0_o, flgf_o};
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    logic [7:0] act;
    act = outs();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {rr,wr,oe,bus,jmp,rtn,f0,ff} actual %b expected %b",
               tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(logic [3:0] op, bit d);
    bit de, wr, bus, jmp, rtn, f0, ff, nskip;
    string tag;
    wr = 0; bus = 0; jmp = 0; rtn = 0; f0 = 0; ff = 0; nskip = 0;
    op_i = op;
    data_i = d;
    if (m_skip) begin
      tag = "R10";
    end else begin
      de = d & m_ien;
      case (op)
        4'h1: m_rr = de;
        4'h2: m_rr = !de;
        4'h3: m_rr = m_rr & de;
        4'h4: m_rr = m_rr & !de;
        4'h5: m_rr = m_rr | de;
        4'h6: m_rr = m_rr | !de;
        4'h7: m_rr = (m_rr == de);
        4'h8: begin wr = m_oen; bus = m_oen & m_rr; end
        4'h9: begin wr = m_oen; bus = m_oen & !m_rr; end
        4'hA: m_ien = d;
        4'hB: m_oen = d;
        4'hC: jmp = 1;
        4'hD: begin rtn = 1; nskip = 1; end
        4'hE: nskip = !m_rr;
        4'h0: f0 = 1;
        default: ff = 1;
      endcase
      if (op >= 4'h1 && op <= 4'h7) tag = m_ien ? "R2" : "R3";
      else if (op == 4'h8 || op == 4'h9) tag = m_oen ? "R4" : "R5";
      else if (op == 4'hA || op == 4'hB) tag = "R6";
      else if (op == 4'hD) tag = "R8";
      else if (op == 4'hE) tag = "R9";
      else tag = "R7";
    end
    m_skip = nskip;
    @(posedge clk);
    @(negedge clk);
    check(tag, {m_rr, wr, wr, bus, jmp, rtn, f0, ff});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_rr = 0; m_ien = 0; m_oen = 0; m_skip = 0;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    @(negedge clk);
    rst = 1'b0;
    for (int ien = 0; ien < 2; ien++)
      for (int oen = 0; oen < 2; oen++)
        for (int rr = 0; rr < 2; rr++)
          for (int d1 = 0; d1 < 2; d1++)
            for (int op1 = 0; op1 < 16; op1++)
              for (int op2 = 0; op2 < 16; op2++) begin
                step(4'h0, 1'b0);
                step(4'hA, 1'b1);
                step(4'h1, bit'(rr));
                step(4'hA, bit'(ien));
                step(4'hB, bit'(oen));
                step(4'(op1), bit'(d1));
                step(4'(op2), !bit'(d1));
                step(4'(op2), bit'(d1));
              end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule